// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Counter

This block is the counting core of a general-purpose timer. A prescaler outside the block supplies a one-cycle count tick. While the core is running, each tick moves a 16-bit count register according to the selected mode: counting up, counting down, counting up and down in a triangle, or following an external pair of signals in which one signal gives the direction and a rising edge on the other gives the tick. A double-step option moves the count by two per tick instead of one. This is useful for doubling the rate of a waveform that is derived from the count.

Software controls the core through a register-style interface. Start and stop strobes enable and halt counting. A write port loads any 16-bit value into the count at any time. A second write port loads the TOP limit. A two-bit mode select and a double-step bit choose how the count moves. The outputs are the count, the current direction, and three one-cycle event pulses: overflow, underflow, and the update event that downstream logic uses to time the reload of buffered values.

Top module: `mm_timer16`

## Requirements
- R1: After a synchronous active-low reset, the count is 0, the TOP register holds 0xFFFF, the core is stopped, and the overflow, underflow and update outputs are 0. With mode 0 selected, the direction output is 0.
- R2: A start strobe makes the core run from the next cycle on. A stop strobe halts it, and stop wins when both strobes are high together. While the core is stopped, the count changes only through a software write.
- R3: In mode 0 (up), each tick adds the step. When a tick arrives while the count is at or above TOP, the count becomes 0 and overflow pulses.
- R4: In mode 1 (down), each tick subtracts the step. When a tick arrives while the count is 0, the count becomes TOP and underflow pulses.
- R5: In mode 2 (up/down), counting starts upward. A tick while the count is at TOP going up gives TOP-1, pulses overflow and turns the direction down. A tick while the count is 0 going down gives 1, pulses underflow and turns the direction up. The direction output is 1 while counting down.
- R6: The update output pulses together with overflow in mode 0, together with underflow in modes 1 and 2, and together with either of them in mode 3.
- R7: With double-step set, each tick moves the count by 2. A step that would pass TOP or 0 stops on that boundary, and a flag is raised only by the following tick.
- R8: In mode 3 (external decoder), a rising edge on the decoder clock input is the count tick and the prescaler tick is ignored. The decoder direction input selects down when it is 1. The count wraps to 0 after TOP going up and to TOP after 0 going down.
- R9: A software count write in the same cycle as a tick takes priority: the count takes the written value and no flag pulses.
- R10: Overflow, underflow and update last exactly one cycle. They appear only in the cycle after a tick that was taken while the core was running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Count tick from the prescaler (modes 0 to 2) |
| cmd_start_i | input | 1 | Start strobe |
| cmd_stop_i | input | 1 | Stop strobe, dominant over start |
| cnt_wr_i | input | 1 | Software count write enable |
| cnt_wdata_i | input | 16 | Value loaded into the count |
| top_wr_i | input | 1 | TOP register write enable |
| top_wdata_i | input | 16 | Value loaded into TOP |
| mode_i | input | 2 | 0 up, 1 down, 2 up/down, 3 external decoder |
| dbl_i | input | 1 | Double-step enable |
| dec_dir_i | input | 1 | Decoder direction, 1 = down |
| dec_clk_i | input | 1 | Decoder clock; its rising edge is a tick in mode 3 |
| cnt_o | output | 16 | Current count |
| dir_o | output | 1 | Current direction, 1 = down |
| ovf_o | output | 1 | Overflow pulse |
| underflow_o | output | 1 | Underflow pulse |
| upd_o | output | 1 | Update event pulse |

## Verification
The bench walks the count through each wrap in every mode and checks the landing value. A design that reuses the single-direction wrap in up/down mode would land on 0 or TOP instead of TOP-1 or 1, and it would also leave the direction output unchanged. Double-step runs start from counts one step short of a boundary, so a core that steps past TOP or 0 shows a wrong value or an early flag. Other tests put a software write on the same cycle as a tick, raise start and stop together, and hold the prescaler tick high in decoder mode. These catch a wrong priority, a start that beats stop, and a decoder that counts on the wrong tick source. The update pulse is checked in every mode, which exposes a core that derives it from the wrong flag.

// File: rtl/tmr_pkg.sv
// Package: shared types for the multi-mode timer core.
// Assumes: the mode encoding below is the one software writes to mode_i.
package tmr_pkg;
    typedef enum logic [1:0] {
        M_UP   = 2'd0,
        M_DOWN = 2'd1,
        M_UPDN = 2'd2,
        M_DEC  = 2'd3
    } tmr_mode_e;
endpackage

// File: rtl/tmr_edge.sv
// Module: tmr_edge
// Gives a one-cycle pulse in the cycle in which sig_i is high after having
// been low in the previous cycle.
// Assumes: sig_i is already synchronous to clk.
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_q;

    // Remember the input level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    // A rise is the present high level against a low one a cycle earlier.
    always_comb rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/tmr_next.sv
// Module: tmr_next
// Purely combinational. Works out the count value after one tick, the wrap
// flags, and the direction that follows, for a given mode and step size.
// Assumes: the caller applies the result only on a tick that is taken.
module tmr_next
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] top_i,
    input  tmr_mode_e    mode_i,
    input  logic         dbl_i,
    input  logic         down_i,
    output logic [W-1:0] nxt_o,
    output logic         ovf_o,
    output logic         unf_o,
    output logic         down_nxt_o
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    logic [W-1:0] step;
    logic         is_updn;

    // Pick the step size and note the triangle mode.
    always_comb begin
        step    = dbl_i ? TWO : ONE;
        is_updn = (mode_i == M_UPDN);
    end

    // Next value: wrap at a boundary, otherwise step and stop on a boundary.
    always_comb begin
        ovf_o      = 1'b0;
        unf_o      = 1'b0;
        nxt_o      = cnt_i;
        down_nxt_o = down_i;
        if (!down_i) begin
            if (cnt_i >= top_i) begin
                ovf_o      = 1'b1;
                nxt_o      = is_updn ? (top_i - ONE) : '0;
                down_nxt_o = is_updn;
            end else if ((top_i - cnt_i) < step) begin
                nxt_o = top_i;
            end else begin
                nxt_o = cnt_i + step;
            end
        end else begin
            if (cnt_i == '0) begin
                unf_o      = 1'b1;
                nxt_o      = is_updn ? ONE : top_i;
                down_nxt_o = !is_updn;
            end else if (cnt_i < step) begin
                nxt_o = '0;
            end else begin
                nxt_o = cnt_i - step;
            end
        end
    end
endmodule

// File: rtl/mm_timer16.sv
// Module: mm_timer16
// Counting core of a general-purpose timer with four modes and a
// double-step option. Holds the count, the TOP limit, the run state and the
// triangle-mode direction. Gives registered one-cycle event pulses.
// Assumes: tick_i comes from a prescaler in the clk domain; dec_clk_i and
// dec_dir_i are already synchronised to clk.
module mm_timer16
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         cmd_start_i,
    input  logic         cmd_stop_i,
    input  logic         cnt_wr_i,
    input  logic [W-1:0] cnt_wdata_i,
    input  logic         top_wr_i,
    input  logic [W-1:0] top_wdata_i,
    input  logic [1:0]   mode_i,
    input  logic         dbl_i,
    input  logic         dec_dir_i,
    input  logic         dec_clk_i,
    output logic [W-1:0] cnt_o,
    output logic         dir_o,
    output logic         ovf_o,
    output logic         underflow_o,
    output logic         upd_o
);
    localparam logic [W-1:0] TOP_RST = '1;

    tmr_mode_e    mode;
    logic [W-1:0] cnt_q, top_q, nxt;
    logic         run_q, dir_q;
    logic         dec_rise, count_en, down_eff;
    logic         n_ovf, n_unf, n_down;
    logic         ovf_q, unf_q, upd_q;

    // Decode the mode select into the shared enum.
    always_comb mode = tmr_mode_e'(mode_i);

    tmr_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (dec_clk_i),
        .rise_o (dec_rise)
    );

    // Effective direction and tick source for the selected mode.
    always_comb begin
        unique case (mode)
            M_UP:    down_eff = 1'b0;
            M_DOWN:  down_eff = 1'b1;
            M_UPDN:  down_eff = dir_q;
            default: down_eff = dec_dir_i;
        endcase
        count_en = run_q && ((mode == M_DEC) ? dec_rise : tick_i);
    end

    tmr_next #(.W(W)) u_next (
        .cnt_i      (cnt_q),
        .top_i      (top_q),
        .mode_i     (mode),
        .dbl_i      (dbl_i),
        .down_i     (down_eff),
        .nxt_o      (nxt),
        .ovf_o      (n_ovf),
        .unf_o      (n_unf),
        .down_nxt_o (n_down)
    );

    // Run state: stop dominates start.
    always_ff @(posedge clk) begin
        if (!rst_n)           run_q <= 1'b0;
        else if (cmd_stop_i)  run_q <= 1'b0;
        else if (cmd_start_i) run_q <= 1'b1;
    end

    // TOP limit register.
    always_ff @(posedge clk) begin
        if (!rst_n)        top_q <= TOP_RST;
        else if (top_wr_i) top_q <= top_wdata_i;
    end

    // Count register: a software write beats a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_wr_i) cnt_q <= cnt_wdata_i;
        else if (count_en) cnt_q <= nxt;
    end

    // Triangle direction; it rests at up outside up/down mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_q <= 1'b0;
        else if (mode != M_UPDN)             dir_q <= 1'b0;
        else if (count_en && !cnt_wr_i)      dir_q <= n_down;
    end

    // Event pulses, raised only for a taken tick without a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            upd_q <= 1'b0;
        end else begin
            ovf_q <= count_en && !cnt_wr_i && n_ovf;
            unf_q <= count_en && !cnt_wr_i && n_unf;
            unique case (mode)
                M_UP:    upd_q <= count_en && !cnt_wr_i && n_ovf;
                M_DEC:   upd_q <= count_en && !cnt_wr_i && (n_ovf || n_unf);
                default: upd_q <= count_en && !cnt_wr_i && n_unf;
            endcase
        end
    end

    // Drive the outputs.
    always_comb begin
        cnt_o       = cnt_q;
        dir_o       = down_eff;
        ovf_o       = ovf_q;
        underflow_o = unf_q;
        upd_o       = upd_q;
    end

    // R2: a stopped core with no write keeps its count.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !cnt_wr_i) |=> (cnt_o == $past(cnt_o)));

    // R9: a write lands as written and raises no flag.
    p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> (cnt_o == $past(cnt_wdata_i)) && !ovf_o && !underflow_o && !upd_o);

    // R10: flags come only from a running tick.
    p_flag_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o || underflow_o || upd_o) |-> $past(count_en));

    // R3: overflow in up mode lands on zero.
    p_ovf_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && $past(mode) == M_UP) |-> (cnt_o == '0));

    // R4: underflow in down mode lands on TOP.
    p_unf_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_o && $past(mode) == M_DOWN) |-> (cnt_o == $past(top_q)));

    // R6: an update never stands alone.
    p_upd_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (ovf_o || underflow_o));
endmodule

// File: tb/sim_mm_timer16.sv
module sim_mm_timer16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, cmd_start_i = 1'b0, cmd_stop_i = 1'b0;
    logic        cnt_wr_i = 1'b0, top_wr_i = 1'b0, dbl_i = 1'b0;
    logic        dec_dir_i = 1'b0, dec_clk_i = 1'b0;
    logic [15:0] cnt_wdata_i = '0, top_wdata_i = '0;
    logic [1:0]  mode_i = 2'd0;
    logic [15:0] cnt_o;
    logic        dir_o, ovf_o, underflow_o, upd_o;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    mm_timer16 u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cmd_start_i(cmd_start_i),
        .cmd_stop_i(cmd_stop_i), .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
        .top_wr_i(top_wr_i), .top_wdata_i(top_wdata_i), .mode_i(mode_i),
        .dbl_i(dbl_i), .dec_dir_i(dec_dir_i), .dec_clk_i(dec_clk_i),
        .cnt_o(cnt_o), .dir_o(dir_o), .ovf_o(ovf_o), .underflow_o(underflow_o),
        .upd_o(upd_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_st(string req, logic [15:0] c, logic o, logic u, logic p, logic d);
        checks++;
        if (cnt_o !== c || ovf_o !== o || underflow_o !== u || upd_o !== p || dir_o !== d) begin
            errors++;
            $display("FAIL %s: cnt/ovf/unf/upd/dir actual %0d/%b/%b/%b/%b expected %0d/%b/%b/%b/%b",
                     req, cnt_o, ovf_o, underflow_o, upd_o, dir_o, c, o, u, p, d);
        end
    endtask

    // Stop, select mode, load TOP and count, then optionally start.
    task automatic setup(logic [1:0] m, logic [15:0] top, logic [15:0] c, logic dbl, bit go);
        cmd_stop_i = 1'b1; mode_i = m; dbl_i = dbl;
        top_wr_i = 1'b1; top_wdata_i = top; cnt_wr_i = 1'b1; cnt_wdata_i = c;
        step();
        cmd_stop_i = 1'b0; top_wr_i = 1'b0; cnt_wr_i = 1'b0;
        if (go) begin
            cmd_start_i = 1'b1;
            step();
            cmd_start_i = 1'b0;
        end
    endtask

    task automatic t_reset();
        expect_st("R1 reset", 16'd0, 0, 0, 0, 0);
    endtask

    task automatic t_start_stop();
        tick_i = 1'b1;
        setup(2'd0, 16'd3, 16'd0, 0, 0);
        step(); step();
        expect_st("R2 stopped holds", 16'd0, 0, 0, 0, 0);
        cmd_start_i = 1'b1; cmd_stop_i = 1'b1;
        step();
        cmd_start_i = 1'b0; cmd_stop_i = 1'b0;
        step();
        expect_st("R2 stop beats start", 16'd0, 0, 0, 0, 0);
    endtask

    task automatic t_up();
        setup(2'd0, 16'd3, 16'd0, 0, 1);
        step(); expect_st("R3 up 1", 16'd1, 0, 0, 0, 0);
        step(); expect_st("R3 up 2", 16'd2, 0, 0, 0, 0);
        step(); expect_st("R3 up 3", 16'd3, 0, 0, 0, 0);
        step(); expect_st("R3 R6 up wrap", 16'd0, 1, 0, 1, 0);
        step(); expect_st("R10 pulse ends", 16'd1, 0, 0, 0, 0);
        tick_i = 1'b0; step();
        expect_st("R10 no tick no count", 16'd1, 0, 0, 0, 0);
        tick_i = 1'b1;
    endtask

    task automatic t_down();
        setup(2'd1, 16'd3, 16'd2, 0, 1);
        step(); expect_st("R4 down 1", 16'd1, 0, 0, 0, 1);
        step(); expect_st("R4 down 0", 16'd0, 0, 0, 0, 1);
        step(); expect_st("R4 R6 down wrap", 16'd3, 0, 1, 1, 1);
        step(); expect_st("R4 after wrap", 16'd2, 0, 0, 0, 1);
    endtask

    task automatic t_updn();
        setup(2'd2, 16'd3, 16'd0, 0, 1);
        step(); expect_st("R5 up 1", 16'd1, 0, 0, 0, 0);
        step(); step(); expect_st("R5 at top", 16'd3, 0, 0, 0, 0);
        step(); expect_st("R5 R6 top turn, no update", 16'd2, 1, 0, 0, 1);
        step(); step(); expect_st("R5 at zero", 16'd0, 0, 0, 0, 1);
        step(); expect_st("R5 R6 zero turn", 16'd1, 0, 1, 1, 0);
        step(); expect_st("R5 up again", 16'd2, 0, 0, 0, 0);
    endtask

    task automatic t_dbl();
        setup(2'd0, 16'd5, 16'd0, 1, 1);
        step(); expect_st("R7 dbl 2", 16'd2, 0, 0, 0, 0);
        step(); expect_st("R7 dbl 4", 16'd4, 0, 0, 0, 0);
        step(); expect_st("R7 clamp top", 16'd5, 0, 0, 0, 0);
        step(); expect_st("R7 wrap after clamp", 16'd0, 1, 0, 1, 0);
        setup(2'd1, 16'd5, 16'd5, 1, 1);
        step(); expect_st("R7 dbl down 3", 16'd3, 0, 0, 0, 1);
        step(); expect_st("R7 dbl down 1", 16'd1, 0, 0, 0, 1);
        step(); expect_st("R7 clamp zero", 16'd0, 0, 0, 0, 1);
        step(); expect_st("R7 down wrap", 16'd5, 0, 1, 1, 1);
        dbl_i = 1'b0;
    endtask

    task automatic dec_pulse();
        dec_clk_i = 1'b1; step();
        dec_clk_i = 1'b0; step();
    endtask

    task automatic t_dec();
        tick_i = 1'b1;
        dec_dir_i = 1'b0;
        setup(2'd3, 16'd3, 16'd1, 0, 1);
        step(); step();
        expect_st("R8 prescaler tick ignored", 16'd1, 0, 0, 0, 0);
        dec_pulse(); expect_st("R8 edge counts once", 16'd2, 0, 0, 0, 0);
        dec_pulse(); dec_clk_i = 1'b1; step();
        expect_st("R8 R6 dec wrap up", 16'd0, 1, 0, 1, 0);
        dec_clk_i = 1'b0; dec_dir_i = 1'b1; step();
        dec_pulse(); expect_st("R8 down edge, flag gone", 16'd3, 0, 0, 0, 1);
        step(); dec_clk_i = 1'b1; step();
        expect_st("R8 dec count down", 16'd2, 0, 0, 0, 1);
        dec_clk_i = 1'b0; dec_dir_i = 1'b0; step();
    endtask

    task automatic t_dec_unf();
        dec_dir_i = 1'b1;
        setup(2'd3, 16'd7, 16'd0, 0, 1);
        dec_clk_i = 1'b1; step();
        expect_st("R8 R6 dec underflow", 16'd7, 0, 1, 1, 1);
        dec_clk_i = 1'b0; dec_dir_i = 1'b0; step();
    endtask

    task automatic t_wr_prio();
        tick_i = 1'b1;
        setup(2'd0, 16'd20, 16'd20, 0, 1);
        cnt_wr_i = 1'b1; cnt_wdata_i = 16'd10; step(); cnt_wr_i = 1'b0;
        expect_st("R9 write beats tick at top", 16'd10, 0, 0, 0, 0);
        step(); expect_st("R9 counts from written", 16'd11, 0, 0, 0, 0);
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1; step();
        t_start_stop();
        t_up();
        t_down();
        t_updn();
        t_dbl();
        t_dec();
        t_dec_unf();
        t_wr_prio();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule